// File: doc/BRIEF.md
# Four-bit character LCD write controller

This block drives a character LCD of the common two-line controller family over a four-bit data bus plus a register-select line and an enable strobe. The bus is write-only: the controller never reads the busy flag and instead waits out a fixed execution delay after every byte.

After reset the block runs the power-on initialization of the display controller on its own. The sequence puts the display into four-bit, two-line mode, turns the display on, clears it and sets left-to-right entry. After that it accepts one byte at a time on a valid/ready handshake. A flag marks each byte as display data or as an instruction. Every byte leaves as two nibbles, high nibble first, and each nibble is latched by its own enable pulse. All timing (setup, enable width, hold, and each delay class) is a parameter in clock cycles. The defaults are derived from the clock frequency.

Top module: `lcd4_wr_ctrl`

## Requirements
- R1: While rst_ni is low, lcd_e_o, lcd_rs_o, lcd_d_o and ready_o are all 0.
- R2: No enable pulse occurs within PWR_CYC cycles after reset is released.
- R3: The first four enable pulses carry single nibbles with register-select 0, in the order 0x3, 0x3, 0x3, 0x2. The enable-low gap after the first is at least BOOT1_CYC cycles, after the second and third at least BOOT2_CYC cycles, and after the fourth at least CMD_CYC cycles.
- R4: The initialization then sends the instruction bytes 0x28, 0x0C, 0x01 and 0x06 in that order, each with register-select 0.
- R5: ready_o stays 0 during the whole initialization. It rises exactly HOLD_CYC + CMD_CYC cycles after the enable falls on the last nibble of 0x06.
- R6: A byte is accepted on a clock edge where valid_i and ready_o are both 1. ready_o is 0 in the next cycle, and enable is never high while ready_o is 1.
- R7: Each accepted byte appears as two enable pulses. The first carries byte_i[7:4] on lcd_d_o and the second byte_i[3:0]. lcd_rs_o equals is_data_i (1 = display data, 0 = instruction) for both pulses.
- R8: Each enable pulse is high for exactly PULSE_CYC cycles. lcd_rs_o and lcd_d_o are stable for at least SETUP_CYC cycles before the rise, throughout the pulse, and for HOLD_CYC cycles after the fall. The two nibbles of one byte are separated by exactly HOLD_CYC + SETUP_CYC low cycles.
- R9: After the second enable pulse of an accepted byte falls, ready_o rises exactly HOLD_CYC + D cycles later. D is SLOW_CYC for an instruction of value 0x01, 0x02 or 0x03 (clear or return home), and CMD_CYC for every other instruction and for all data bytes.
- R10: valid_i asserted while ready_o is 0 has no effect: no additional nibble appears on the bus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Byte offered |
| ready_o | output | 1 | Controller can take a byte |
| is_data_i | input | 1 | 1 = display data, 0 = instruction |
| byte_i | input | 8 | Byte to send |
| lcd_e_o | output | 1 | Enable strobe to the display |
| lcd_rs_o | output | 1 | Register select to the display |
| lcd_d_o | output | 4 | Data nibble to the display |

## Verification
A wrong nibble phase or stale byte register shows up on the very next enable pulse, as a wrong nibble or swapped halves. A wrong delay class or miscounted timer shows up at the moment ready rises, one cycle early or late against the exact count. A stuck initialization step index shows up as a repeated or missing boot byte before ready ever rises. A handshake that accepts while busy shows up as an extra pair of pulses that the expected queue does not contain.

// File: rtl/lcd4_pkg.sv
package lcd4_pkg;

  typedef enum logic [1:0] {
    WAIT_BOOT1,
    WAIT_BOOT2,
    WAIT_CMD,
    WAIT_SLOW
  } wait_e;

  typedef struct packed {
    logic       two_nib;
    logic [7:0] val;
    wait_e      dly;
  } step_t;

  localparam int unsigned BOOT_STEPS = 8;
  localparam int unsigned STEP_W     = $clog2(BOOT_STEPS);

  function automatic int unsigned max2(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

  // single-nibble steps carry the nibble in val[7:4]
  function automatic step_t boot_step(input logic [STEP_W-1:0] idx);
    step_t s;
    s.two_nib = 1'b1;
    s.dly     = WAIT_CMD;
    s.val     = 8'h00;
    case (idx)
      3'd0: begin s.two_nib = 1'b0; s.val = 8'h30; s.dly = WAIT_BOOT1; end
      3'd1: begin s.two_nib = 1'b0; s.val = 8'h30; s.dly = WAIT_BOOT2; end
      3'd2: begin s.two_nib = 1'b0; s.val = 8'h30; s.dly = WAIT_BOOT2; end
      3'd3: begin s.two_nib = 1'b0; s.val = 8'h20; end
      3'd4: s.val = 8'h28;
      3'd5: s.val = 8'h0C;
      3'd6: begin s.val = 8'h01; s.dly = WAIT_SLOW; end
      default: s.val = 8'h06;
    endcase
    return s;
  endfunction

  // clear display and return home need the long execution time
  function automatic logic is_slow(input logic rs, input logic [7:0] b);
    return !rs && (b[7:2] == 6'd0) && (b[1:0] != 2'd0);
  endfunction

endpackage

// File: rtl/lcd4_timer.sv
module lcd4_timer #(
  parameter int unsigned W       = 8,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] val_i,
  output logic         expired_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= RST_VAL;
    else if (load_i)          cnt_q <= val_i;
    else if (cnt_q != '0)     cnt_q <= cnt_q - 1'b1;
  end

  assign expired_o = (cnt_q == '0);
endmodule

// File: rtl/lcd4_strobe.sv
module lcd4_strobe #(
  parameter int unsigned SETUP_CYC = 2,
  parameter int unsigned PULSE_CYC = 3,
  parameter int unsigned HOLD_CYC  = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  input  logic       two_i,
  input  logic       rs_i,
  input  logic [7:0] byte_i,
  output logic       done_o,
  output logic       e_o,
  output logic       rs_o,
  output logic [3:0] d_o
);
  import lcd4_pkg::*;

  localparam int unsigned PW = $clog2(max2(max2(SETUP_CYC, PULSE_CYC), HOLD_CYC) + 1);
  localparam logic [PW-1:0] SU_M1 = PW'(SETUP_CYC - 1);
  localparam logic [PW-1:0] EH_M1 = PW'(PULSE_CYC - 1);
  localparam logic [PW-1:0] HD_M1 = PW'(HOLD_CYC - 1);

  typedef enum logic [1:0] {PH_IDLE, PH_SU, PH_EH, PH_HD} ph_e;

  ph_e           ph_q;
  logic [PW-1:0] cnt_q;
  logic          two_q, lo_q, rs_q;
  logic [7:0]    byte_q;
  logic          more;

  assign more = two_q && !lo_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q   <= PH_IDLE;
      cnt_q  <= '0;
      two_q  <= 1'b0;
      lo_q   <= 1'b0;
      rs_q   <= 1'b0;
      byte_q <= 8'h00;
    end else begin
      case (ph_q)
        PH_IDLE: if (start_i) begin
          two_q  <= two_i;
          lo_q   <= 1'b0;
          rs_q   <= rs_i;
          byte_q <= byte_i;
          ph_q   <= PH_SU;
          cnt_q  <= SU_M1;
        end
        PH_SU: if (cnt_q == '0) begin
          ph_q  <= PH_EH;
          cnt_q <= EH_M1;
        end else cnt_q <= cnt_q - 1'b1;
        PH_EH: if (cnt_q == '0) begin
          ph_q  <= PH_HD;
          cnt_q <= HD_M1;
        end else cnt_q <= cnt_q - 1'b1;
        default: if (cnt_q == '0) begin
          if (more) begin
            lo_q  <= 1'b1;
            ph_q  <= PH_SU;
            cnt_q <= SU_M1;
          end else ph_q <= PH_IDLE;
        end else cnt_q <= cnt_q - 1'b1;
      endcase
    end
  end

  assign done_o = (ph_q == PH_HD) && (cnt_q == '0) && !more;
  assign e_o    = (ph_q == PH_EH);
  assign rs_o   = rs_q;
  assign d_o    = lo_q ? byte_q[3:0] : byte_q[7:4];

  assert_setup_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(e_o) |-> ($stable(rs_o) && $stable(d_o)));
  assert_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(e_o) |-> ($stable(rs_o) && $stable(d_o)));
  assert_high_stable_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (e_o && $past(e_o)) |-> $stable(d_o));
endmodule

// File: rtl/lcd4_seq.sv
module lcd4_seq #(
  parameter int unsigned TW        = 8,
  parameter int unsigned PWR_CYC   = 40,
  parameter int unsigned BOOT1_CYC = 30,
  parameter int unsigned BOOT2_CYC = 10,
  parameter int unsigned CMD_CYC   = 6,
  parameter int unsigned SLOW_CYC  = 20
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       valid_i,
  output logic       ready_o,
  input  logic       is_data_i,
  input  logic [7:0] byte_i,
  input  logic       done_i,
  output logic       start_o,
  output logic       two_o,
  output logic       rs_o,
  output logic [7:0] byte_o
);
  import lcd4_pkg::*;

  localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(BOOT_STEPS - 1);

  typedef enum logic [2:0] {S_BOOT, S_LOAD, S_SEND, S_WAIT, S_IDLE} st_e;

  st_e               st_q;
  logic [STEP_W-1:0] step_q;
  logic              booting_q;
  wait_e             dly_q;
  step_t             cur;
  logic              tmr_load, tmr_exp;
  logic [TW-1:0]     tmr_val;

  assign cur = boot_step(step_q);

  always_comb begin
    start_o = 1'b0;
    two_o   = 1'b1;
    rs_o    = is_data_i;
    byte_o  = byte_i;
    if (st_q == S_LOAD) begin
      start_o = 1'b1;
      two_o   = cur.two_nib;
      rs_o    = 1'b0;
      byte_o  = cur.val;
    end else if (st_q == S_IDLE) begin
      start_o = valid_i;
    end
  end

  always_comb begin
    case (dly_q)
      WAIT_BOOT1: tmr_val = TW'(BOOT1_CYC - 1);
      WAIT_BOOT2: tmr_val = TW'(BOOT2_CYC - 1);
      WAIT_SLOW:  tmr_val = TW'(SLOW_CYC - 1);
      default:    tmr_val = TW'(CMD_CYC - 1);
    endcase
  end

  assign tmr_load = (st_q == S_SEND) && done_i;

  lcd4_timer #(.W(TW), .RST_VAL(TW'(PWR_CYC - 1))) u_tmr (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (tmr_load),
    .val_i    (tmr_val),
    .expired_o(tmr_exp)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= S_BOOT;
      step_q    <= '0;
      booting_q <= 1'b1;
      dly_q     <= WAIT_CMD;
    end else begin
      case (st_q)
        S_BOOT: if (tmr_exp) st_q <= S_LOAD;
        S_LOAD: begin
          dly_q <= cur.dly;
          st_q  <= S_SEND;
        end
        S_IDLE: if (valid_i) begin
          dly_q <= is_slow(is_data_i, byte_i) ? WAIT_SLOW : WAIT_CMD;
          st_q  <= S_SEND;
        end
        S_SEND: if (done_i) st_q <= S_WAIT;
        default: if (tmr_exp) begin
          if (!booting_q) st_q <= S_IDLE;
          else if (step_q == LAST_STEP) begin
            booting_q <= 1'b0;
            st_q      <= S_IDLE;
          end else begin
            step_q <= step_q + 1'b1;
            st_q   <= S_LOAD;
          end
        end
      endcase
    end
  end

  assign ready_o = (st_q == S_IDLE);

  assert_accept_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && ready_o) |=> !ready_o);
  assert_boot_busy_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    booting_q |-> !ready_o);
  assert_busy_no_start_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == S_SEND || st_q == S_WAIT) |-> !start_o);
endmodule

// File: rtl/lcd4_wr_ctrl.sv
module lcd4_wr_ctrl #(
  parameter int unsigned CLK_HZ    = 50_000_000,
  parameter int unsigned SETUP_CYC = CLK_HZ / 20_000_000 + 1,
  parameter int unsigned PULSE_CYC = (CLK_HZ + 999_999) / 1_000_000,
  parameter int unsigned HOLD_CYC  = CLK_HZ / 20_000_000 + 1,
  parameter int unsigned PWR_CYC   = CLK_HZ / 25,
  parameter int unsigned BOOT1_CYC = CLK_HZ / 10_000 * 41,
  parameter int unsigned BOOT2_CYC = CLK_HZ / 10_000,
  parameter int unsigned CMD_CYC   = CLK_HZ / 25_000,
  parameter int unsigned SLOW_CYC  = CLK_HZ / 10_000 * 16
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       valid_i,
  output logic       ready_o,
  input  logic       is_data_i,
  input  logic [7:0] byte_i,
  output logic       lcd_e_o,
  output logic       lcd_rs_o,
  output logic [3:0] lcd_d_o
);
  import lcd4_pkg::*;

  localparam int unsigned TMAX = max2(max2(max2(PWR_CYC, BOOT1_CYC), max2(BOOT2_CYC, CMD_CYC)), SLOW_CYC);
  localparam int unsigned TW   = $clog2(TMAX + 1);

  logic       start, two, rs, done;
  logic [7:0] tx_byte;

  lcd4_seq #(
    .TW(TW), .PWR_CYC(PWR_CYC), .BOOT1_CYC(BOOT1_CYC), .BOOT2_CYC(BOOT2_CYC),
    .CMD_CYC(CMD_CYC), .SLOW_CYC(SLOW_CYC)
  ) u_seq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .valid_i  (valid_i),
    .ready_o  (ready_o),
    .is_data_i(is_data_i),
    .byte_i   (byte_i),
    .done_i   (done),
    .start_o  (start),
    .two_o    (two),
    .rs_o     (rs),
    .byte_o   (tx_byte)
  );

  lcd4_strobe #(
    .SETUP_CYC(SETUP_CYC), .PULSE_CYC(PULSE_CYC), .HOLD_CYC(HOLD_CYC)
  ) u_strobe (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(start),
    .two_i  (two),
    .rs_i   (rs),
    .byte_i (tx_byte),
    .done_o (done),
    .e_o    (lcd_e_o),
    .rs_o   (lcd_rs_o),
    .d_o    (lcd_d_o)
  );

  assert_idle_no_strobe_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |-> !lcd_e_o);
  assert_done_closes_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done |=> !lcd_e_o && !ready_o);
endmodule

// File: tb/tb_lcd4_wr_ctrl.sv
module tb_lcd4_wr_ctrl;
  localparam int SU = 2, EH = 3, HD = 2, PWR = 40, W1 = 30, W2 = 10, CMD = 6, SLOW = 20;

  typedef struct {
    bit        rs;
    bit [3:0]  nib;
    int        gap;
    bit        exact;
    bit        last;
    int        dly;
    string     req;
  } nib_t;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       valid = 1'b0;
  logic       is_data = 1'b0;
  logic [7:0] byte_v = 8'h00;
  logic       ready, lcd_e, lcd_rs;
  logic [3:0] lcd_d;

  int   n_chk = 0, n_bad = 0;
  bit   finished = 1'b0;
  nib_t q[$];
  nib_t cur;
  int   prev_dly = CMD;

  lcd4_wr_ctrl #(
    .SETUP_CYC(SU), .PULSE_CYC(EH), .HOLD_CYC(HD), .PWR_CYC(PWR),
    .BOOT1_CYC(W1), .BOOT2_CYC(W2), .CMD_CYC(CMD), .SLOW_CYC(SLOW)
  ) dut (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid), .ready_o(ready),
    .is_data_i(is_data), .byte_i(byte_v),
    .lcd_e_o(lcd_e), .lcd_rs_o(lcd_rs), .lcd_d_o(lcd_d)
  );

  always #10 clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic nib_t mk(input bit rs, input bit [3:0] n, input int gap, input bit ex,
                              input bit last, input int dly, input string req);
    nib_t e;
    e.rs = rs; e.nib = n; e.gap = gap; e.exact = ex; e.last = last; e.dly = dly; e.req = req;
    return e;
  endfunction

  task automatic push_byte(input bit rs, input [7:0] b, input bit last, input int dly, input string req);
    q.push_back(mk(rs, b[7:4], HD + prev_dly + SU, 1'b0, 1'b0, 0, req));
    q.push_back(mk(rs, b[3:0], HD + SU, 1'b1, last, dly, req));
    prev_dly = dly;
  endtask

  // monitor: sampled on falling edge
  bit prev_e = 0, prev_rs = 0, armed = 0, rdy_ok = 0;
  bit [3:0] prev_d = 0;
  int low_cnt = 0, hi_cnt = 0, stab = 0, pulses = 0, rdy_cnt = 0, rdy_exp = 0;
  string rdy_req;

  always @(negedge clk) begin
    if (!rst_n) begin
      prev_e = 0; prev_rs = 0; prev_d = 0; low_cnt = 0; hi_cnt = 0; stab = 0;
      pulses = 0; armed = 0; rdy_ok = 0;
    end else begin
      bit rise, fall, changed;
      rise    = lcd_e && !prev_e;
      fall    = !lcd_e && prev_e;
      changed = (lcd_rs != prev_rs) || (lcd_d != prev_d);
      if (armed) begin
        if (ready) begin
          chk(rdy_cnt == rdy_exp, rdy_req, rdy_cnt, rdy_exp);
          armed = 0;
          if (rdy_req == "R5") rdy_ok = 1;
        end else rdy_cnt++;
      end
      if (ready && !rdy_ok) chk(0, "R5 ready during boot", 1, 0);
      if (fall) begin
        low_cnt = 1;
        chk(hi_cnt == EH, "R8 pulse width", hi_cnt, EH);
        if (cur.last) begin
          armed = 1; rdy_cnt = 1; rdy_exp = HD + cur.dly;
          rdy_req = (cur.req == "R4") ? "R5" : "R9";
        end
      end else if (!lcd_e) low_cnt++;
      if (lcd_e) hi_cnt = rise ? 1 : hi_cnt + 1;
      if (changed) begin
        stab = 1;
        if (lcd_e) chk(0, "R8 data moved while high", 1, 0);
        else if (pulses > 0) chk(low_cnt > HD, "R8 hold", low_cnt, HD + 1);
      end else stab++;
      if (rise) begin
        pulses++;
        chk(stab >= SU + 1, "R8 setup", stab, SU + 1);
        if (q.size() == 0) chk(0, "R10 unexpected strobe", lcd_d, -1);
        else begin
          cur = q.pop_front();
          chk(lcd_rs == cur.rs, {cur.req, " rs"}, lcd_rs, cur.rs);
          chk(lcd_d == cur.nib, {cur.req, " nibble"}, lcd_d, cur.nib);
          if (cur.exact) chk(low_cnt == cur.gap, "R8 nibble gap", low_cnt, cur.gap);
          else chk(low_cnt >= cur.gap, (pulses == 1) ? "R2 power-up wait" : "R3 R9 delay", low_cnt, cur.gap);
        end
      end
      prev_e = lcd_e; prev_rs = lcd_rs; prev_d = lcd_d;
    end
  end

  task automatic send(input bit rs, input [7:0] b);
    bit slow;
    slow = !rs && (b == 8'h01 || b == 8'h02 || b == 8'h03);
    is_data = rs; byte_v = b; valid = 1'b1;
    while (!ready) @(negedge clk);
    push_byte(rs, b, 1'b1, slow ? SLOW : CMD, "R7");
    @(negedge clk);
    valid = 1'b0;
    chk(ready == 1'b0, "R6 ready drop", ready, 0);
  endtask

  task automatic poke(input [7:0] b);
    is_data = 1'b1; byte_v = b; valid = 1'b1;
    for (int i = 0; i < 3; i++) begin
      chk(ready == 1'b0, "R10 busy while poking", ready, 0);
      @(negedge clk);
    end
    valid = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(lcd_e == 0, "R1 e", lcd_e, 0);
    chk(lcd_rs == 0, "R1 rs", lcd_rs, 0);
    chk(lcd_d == 0, "R1 d", lcd_d, 0);
    chk(ready == 0, "R1 ready", ready, 0);
    q.push_back(mk(0, 4'h3, PWR + SU, 0, 0, 0, "R3"));
    q.push_back(mk(0, 4'h3, HD + W1 + SU, 0, 0, 0, "R3"));
    q.push_back(mk(0, 4'h3, HD + W2 + SU, 0, 0, 0, "R3"));
    q.push_back(mk(0, 4'h2, HD + W2 + SU, 0, 0, 0, "R3"));
    prev_dly = CMD;
    push_byte(0, 8'h28, 0, CMD, "R4");
    push_byte(0, 8'h0C, 0, CMD, "R4");
    push_byte(0, 8'h01, 0, SLOW, "R4");
    push_byte(0, 8'h06, 1, CMD, "R4");
    rst_n = 1'b1;
    repeat (10) @(negedge clk);
    poke(8'hFF);
    while (!ready) @(negedge clk);
    send(0, 8'h80);
    poke(8'h55);
    send(1, 8'h48);
    send(1, 8'h01);
    send(0, 8'h01);
    send(0, 8'h02);
    send(0, 8'h03);
    send(0, 8'h04);
    send(1, 8'hA5);
    send(0, 8'h0C);
    while (!ready) @(negedge clk);
    repeat (5) @(negedge clk);
    send(0, 8'h18);
    while (!(ready && q.size() == 0 && !armed)) @(negedge clk);
    repeat (5) @(negedge clk);
    chk(q.size() == 0, "R10 leftover", q.size(), 0);
    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule